// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Burst Address Counters

This block is a true dual-port synchronous static RAM. Its two ports, called A and B, share one clock. Each port can read or write any word at any time. A word is `DW` bits wide, 16 or 18, and is split into a lower byte lane and an upper byte lane of `DW/2` bits each. Every write and every read output can be gated per lane.

Each port takes its address from its own burst counter, not straight from its address pins. On every rising edge the counter does one of four things:

- clears to zero,
- loads the external address,
- steps up by one, wrapping at the top of the array, or
- holds its value.

The address used for the access in that cycle is the counter's new value. The counter acts whether or not the port is selected. A caller can therefore set up a burst start address while the port is idle, then stream sequential accesses by holding only the increment control low.

Each port has its own mode bit that picks the read latency. In flow-through mode, read data appears after the edge that performed the read. In pipelined mode, read data appears one clock later. When both ports write the same word on the same edge, port A wins in every lane that both ports write. A read that lands on a word the other port writes on the same edge returns the stored value from before that write.

Top module: `dpram_burst`

## Requirements
- R1: While reset is asserted, both ports hold `x_dout_en` at 2'b00. After reset, each port's counter holds address 0, and the memory contents are kept across reset.
- R2: With `x_clr_n` low at an edge, the access in that cycle uses address 0 and the counter becomes 0. This overrides load and increment.
- R3: With `x_clr_n` high and `x_ld_n` low, the access uses `x_addr` and the counter takes that value. This overrides increment.
- R4: With `x_clr_n`, `x_ld_n` and `x_inc_n` all high, the counter keeps its value, the access reuses it, and `x_addr` has no effect.
- R5: With `x_clr_n` and `x_ld_n` high and `x_inc_n` low, the access uses the counter value plus one. From the top address, the counter wraps to 0.
- R6: Counter clear, load and increment take effect on every edge, including when the port is deselected.
- R7: A port is selected only when `x_cs_n` is low and `x_cs` is high. When deselected, the port writes nothing and produces no read output (`x_dout_en` = 2'b00 in flow-through mode).
- R8: Lane enable bit 0 / `x_lb_n` controls data bits [DW/2-1:0]. Lane enable bit 1 / `x_ub_n` controls bits [DW-1:DW/2]. Both are active low. A write changes only the enabled lanes. A read drives only the enabled lanes, each shown on the matching bit of `x_dout_en`, with disabled lanes reading as 0.
- R9: With `x_pipe` = 0, read data and enables appear after the read edge. With `x_pipe` = 1, they appear one clock edge later.
- R10: While `x_oe_n` is high, `x_dout_en` is 2'b00 and `x_dout` is 0. Lowering `x_oe_n` shows the held read data at once, without waiting for a clock edge.
- R11: When both ports write the same address on one edge, port A's data is stored in each lane that both ports write.
- R12: A read on one port at the address the other port writes on the same edge returns the data stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_addr | input | AW | Port A external address |
| a_cs_n | input | 1 | Port A active-low select |
| a_cs | input | 1 | Port A active-high select |
| a_ub_n | input | 1 | Port A upper lane enable, active low |
| a_lb_n | input | 1 | Port A lower lane enable, active low |
| a_wr_n | input | 1 | Port A write (low) / read (high) |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_ld_n | input | 1 | Port A counter load, active low |
| a_inc_n | input | 1 | Port A counter increment, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_pipe | input | 1 | Port A read mode: 0 flow-through, 1 pipelined |
| a_din | input | DW | Port A write data |
| a_dout | output | DW | Port A read data |
| a_dout_en | output | 2 | Port A per-lane read valid (bit 1 upper) |
| b_addr | input | AW | Port B external address |
| b_cs_n | input | 1 | Port B active-low select |
| b_cs | input | 1 | Port B active-high select |
| b_ub_n | input | 1 | Port B upper lane enable, active low |
| b_lb_n | input | 1 | Port B lower lane enable, active low |
| b_wr_n | input | 1 | Port B write (low) / read (high) |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_ld_n | input | 1 | Port B counter load, active low |
| b_inc_n | input | 1 | Port B counter increment, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_pipe | input | 1 | Port B read mode: 0 flow-through, 1 pipelined |
| b_din | input | DW | Port B write data |
| b_dout | output | DW | Port B read data |
| b_dout_en | output | 2 | Port B per-lane read valid (bit 1 upper) |

## Verification
The hardest cases to reach from the ports are the counter's hidden state and the two-port collisions. The counter can only be seen through the data it addresses. The bench therefore first writes distinct words at known addresses. It then moves the counter while the port is deselected and reads back after a hold or increment, so the returned word shows which address was used. For the wrap case, the bench loads the top address and then increments. Collisions need both ports driven on the same edge. The bench sets up both ports together before a single clock step, then reads the word back afterwards to see which lanes port A owned.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int LANES = 2;

  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic             sel;
    logic             wr;
    logic [LANES-1:0] lane;
  } access_t;
endpackage

// File: rtl/dpb_burst_counter.sv
module dpb_burst_counter #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic          inc_n,
  output logic [AW-1:0] use_addr
);
  logic [AW-1:0] cnt_d;
  logic [AW-1:0] cnt_r;

  // priority: clear, then load, then increment, else hold
  always_comb begin
    if (!clr_n)      cnt_d = '0;
    else if (!ld_n)  cnt_d = ext_addr;
    else if (!inc_n) cnt_d = cnt_r + AW'(1);
    else             cnt_d = cnt_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_d;
  end

  assign use_addr = cnt_d;
endmodule

// File: rtl/dpb_read_stage.sv
module dpb_read_stage #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [1:0]    lane_en,
  input  logic [DW-1:0] rd_word,
  input  logic          pipe,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic [1:0]    dout_en
);
  import dpb_pkg::*;
  localparam int LW = DW / 2;

  logic [DW-1:0] s1_data, s2_data;
  logic [1:0]    s1_vld, s2_vld;
  logic [1:0]    s1_vld_d;
  logic          s2_load;
  logic [1:0]    vld_sel;
  rd_mode_e      mode;

  assign s1_vld_d = cap_en ? lane_en : 2'b00;
  assign s2_load  = |s1_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 2'b00;
      s2_vld <= 2'b00;
    end else begin
      s1_vld <= s1_vld_d;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en)  s1_data <= rd_word;
    if (s2_load) s2_data <= s1_data;
  end

  assign mode    = rd_mode_e'(pipe);
  assign vld_sel = (mode == MODE_PIPE) ? s2_vld : s1_vld;
  assign dout_en = vld_sel & {2{~oe_n}};

  always_comb begin
    logic [DW-1:0] src;
    src  = (mode == MODE_PIPE) ? s2_data : s1_data;
    dout = '0;
    if (dout_en[0]) dout[LW-1:0]  = src[LW-1:0];
    if (dout_en[1]) dout[DW-1:LW] = src[DW-1:LW];
  end
endmodule

// File: rtl/dpram_burst.sv
module dpram_burst #(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic          a_cs_n,
  input  logic          a_cs,
  input  logic          a_ub_n,
  input  logic          a_lb_n,
  input  logic          a_wr_n,
  input  logic          a_oe_n,
  input  logic          a_ld_n,
  input  logic          a_inc_n,
  input  logic          a_clr_n,
  input  logic          a_pipe,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic [1:0]    a_dout_en,
  input  logic [AW-1:0] b_addr,
  input  logic          b_cs_n,
  input  logic          b_cs,
  input  logic          b_ub_n,
  input  logic          b_lb_n,
  input  logic          b_wr_n,
  input  logic          b_oe_n,
  input  logic          b_ld_n,
  input  logic          b_inc_n,
  input  logic          b_clr_n,
  input  logic          b_pipe,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic [1:0]    b_dout_en
);
  import dpb_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam int LW    = DW / 2;
  localparam int NP    = 2;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [AW-1:0] ext_p  [NP];
  logic          csn_p  [NP];
  logic          cs_p   [NP];
  logic          ubn_p  [NP];
  logic          lbn_p  [NP];
  logic          wrn_p  [NP];
  logic          oen_p  [NP];
  logic          ldn_p  [NP];
  logic          incn_p [NP];
  logic          clrn_p [NP];
  logic          pipe_p [NP];
  logic [DW-1:0] din_p  [NP];
  logic [DW-1:0] dout_p [NP];
  logic [1:0]    doen_p [NP];
  logic [AW-1:0] use_p  [NP];
  logic [DW-1:0] rd_p   [NP];
  access_t       acc_p  [NP];

  assign ext_p[0] = a_addr;  assign ext_p[1] = b_addr;
  assign csn_p[0] = a_cs_n;  assign csn_p[1] = b_cs_n;
  assign cs_p[0]  = a_cs;    assign cs_p[1]  = b_cs;
  assign ubn_p[0] = a_ub_n;  assign ubn_p[1] = b_ub_n;
  assign lbn_p[0] = a_lb_n;  assign lbn_p[1] = b_lb_n;
  assign wrn_p[0] = a_wr_n;  assign wrn_p[1] = b_wr_n;
  assign oen_p[0] = a_oe_n;  assign oen_p[1] = b_oe_n;
  assign ldn_p[0] = a_ld_n;  assign ldn_p[1] = b_ld_n;
  assign incn_p[0] = a_inc_n; assign incn_p[1] = b_inc_n;
  assign clrn_p[0] = a_clr_n; assign clrn_p[1] = b_clr_n;
  assign pipe_p[0] = a_pipe; assign pipe_p[1] = b_pipe;
  assign din_p[0] = a_din;   assign din_p[1] = b_din;
  assign a_dout = dout_p[0]; assign a_dout_en = doen_p[0];
  assign b_dout = dout_p[1]; assign b_dout_en = doen_p[1];

  logic [DW-1:0] mem [DEPTH];

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpb_burst_counter #(.AW(AW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_q),
      .ext_addr (ext_p[p]),
      .clr_n    (clrn_p[p]),
      .ld_n     (ldn_p[p]),
      .inc_n    (incn_p[p]),
      .use_addr (use_p[p])
    );

    always_comb begin
      acc_p[p].sel  = rst_q & ~csn_p[p] & cs_p[p];
      acc_p[p].wr   = ~wrn_p[p];
      acc_p[p].lane = {~ubn_p[p], ~lbn_p[p]};
    end

    assign rd_p[p] = mem[use_p[p]];

    dpb_read_stage #(.DW(DW)) u_rd (
      .clk     (clk),
      .rst_n   (rst_q),
      .cap_en  (acc_p[p].sel & ~acc_p[p].wr),
      .lane_en (acc_p[p].lane),
      .rd_word (rd_p[p]),
      .pipe    (pipe_p[p]),
      .oe_n    (oen_p[p]),
      .dout    (dout_p[p]),
      .dout_en (doen_p[p])
    );
  end

  // port B applied first so that port A's lanes land last and win
  always_ff @(posedge clk) begin
    for (int p = NP - 1; p >= 0; p--) begin
      if (acc_p[p].sel && acc_p[p].wr) begin
        if (acc_p[p].lane[0]) mem[use_p[p]][LW-1:0]  <= din_p[p][LW-1:0];
        if (acc_p[p].lane[1]) mem[use_p[p]][DW-1:LW] <= din_p[p][DW-1:LW];
      end
    end
  end
endmodule

// File: rtl/dpb_checkers.sv
module dpb_cnt_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          clr_n,
  input logic          ld_n,
  input logic          inc_n,
  input logic [AW-1:0] cnt_r
);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> cnt_r == '0);
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> cnt_r == $past(ext_addr));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && inc_n) |=> $stable(cnt_r));
  assert_incr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !inc_n) |=> cnt_r == AW'($past(cnt_r) + AW'(1)));
endmodule

module dpb_out_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          pipe,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic [1:0]    dout_en
);
  assert_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !pipe) |=> (pipe || dout_en == 2'b00));
  assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dout_en == 2'b00 && dout == '0));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> dout_en == 2'b00);
endmodule

bind dpb_burst_counter dpb_cnt_chk #(.AW(AW)) u_cnt_chk (
  .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .clr_n(clr_n),
  .ld_n(ld_n), .inc_n(inc_n), .cnt_r(cnt_r)
);

bind dpb_read_stage dpb_out_chk #(.DW(DW)) u_out_chk (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pipe(pipe), .oe_n(oe_n),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/dpram_burst_tb.sv
module dpram_burst_tb;
  localparam int AW = 8;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [AW-1:0] a_addr, b_addr;
  logic a_cs_n, a_cs, a_ub_n, a_lb_n, a_wr_n, a_oe_n, a_ld_n, a_inc_n, a_clr_n, a_pipe;
  logic b_cs_n, b_cs, b_ub_n, b_lb_n, b_wr_n, b_oe_n, b_ld_n, b_inc_n, b_clr_n, b_pipe;
  logic [DW-1:0] a_din, b_din, a_dout, b_dout;
  logic [1:0] a_dout_en, b_dout_en;

  dpram_burst #(.AW(AW), .DW(DW)) u_dut (.*);

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  typedef struct packed {
    logic [7:0]  addr;
    logic [17:0] wd;
    logic [1:0]  lanes;
    logic [17:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'h10, 18'h3FFFF, 2'b11, 18'h3FFFF},
    '{8'h10, 18'h00000, 2'b01, 18'h3FE00},
    '{8'h20, 18'h12345, 2'b11, 18'h12345},
    '{8'h20, 18'h3FFFF, 2'b10, 18'h3FF45},
    '{8'hFF, 18'h2AAAA, 2'b11, 18'h2AAAA},
    '{8'h00, 18'h15555, 2'b11, 18'h15555},
    '{8'h00, 18'h00000, 2'b00, 18'h15555},
    '{8'h7F, 18'h0ABCD, 2'b11, 18'h0ABCD}
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_cs_n = 1; a_cs = 0; a_ub_n = 0; a_lb_n = 0; a_wr_n = 1; a_oe_n = 0;
    a_ld_n = 1; a_inc_n = 1; a_clr_n = 1;
    b_cs_n = 1; b_cs = 0; b_ub_n = 0; b_lb_n = 0; b_wr_n = 1; b_oe_n = 0;
    b_ld_n = 1; b_inc_n = 1; b_clr_n = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic a_wr(input logic [7:0] ad, input logic [17:0] d, input logic [1:0] ln);
    a_cs_n = 0; a_cs = 1; a_ld_n = 0; a_addr = ad; a_wr_n = 0; a_din = d;
    a_ub_n = ~ln[1]; a_lb_n = ~ln[0];
  endtask

  task automatic b_rd_ld(input logic [7:0] ad);
    b_cs_n = 0; b_cs = 1; b_ld_n = 0; b_addr = ad; b_wr_n = 1;
  endtask

  initial begin
    rst_n = 0; a_pipe = 0; b_pipe = 0; a_addr = '0; b_addr = '0;
    a_din = '0; b_din = '0;
    idle();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset A en", {16'h0, a_dout_en}, 18'h0);
    chk("R1 reset B en", {16'h0, b_dout_en}, 18'h0);
    @(negedge clk); rst_n = 1;
    repeat (3) tick();

    // table: write through A (R3 load, R8 lanes), read back through B flow-through (R9)
    for (int i = 0; i < 8; i++) begin
      a_wr(VEC[i].addr, VEC[i].wd, VEC[i].lanes);
      tick();
      b_rd_ld(VEC[i].addr);
      tick();
      chk("R8 table data", b_dout, VEC[i].exp);
      chk("R9 flow en", {16'h0, b_dout_en}, 18'h3);
    end

    // R2: clear overrides load
    b_rd_ld(8'h10); b_clr_n = 0; tick();
    chk("R2 clear wins", b_dout, 18'h15555);

    // R5: wrap from top address
    b_rd_ld(8'hFF); tick();
    chk("R3 load FF", b_dout, 18'h2AAAA);
    b_cs_n = 0; b_cs = 1; b_inc_n = 0; tick();
    chk("R5 wrap to 0", b_dout, 18'h15555);

    // R6: load while deselected, then increment
    b_ld_n = 0; b_addr = 8'h1F; tick();
    chk("R7 desel no out", {16'h0, b_dout_en}, 18'h0);
    b_cs_n = 0; b_cs = 1; b_inc_n = 0; b_addr = 8'h10; tick();
    chk("R6 R5 inc after desel load", b_dout, 18'h3FF45);

    // R4: hold ignores external address
    b_cs_n = 0; b_cs = 1; b_addr = 8'h10; tick();
    chk("R4 hold", b_dout, 18'h3FF45);

    // R7: deselected write has no effect
    a_wr(8'h20, 18'h00000, 2'b11); a_cs_n = 1; tick();
    b_rd_ld(8'h20); tick();
    chk("R7 desel write", b_dout, 18'h3FF45);
    a_wr(8'h20, 18'h00000, 2'b11); a_cs = 0; tick();
    b_rd_ld(8'h20); tick();
    chk("R7 cs low write", b_dout, 18'h3FF45);

    // R8: read with upper lane disabled
    b_rd_ld(8'h20); b_ub_n = 1; tick();
    chk("R8 lane en", {16'h0, b_dout_en}, 18'h1);
    chk("R8 lane data", b_dout, 18'h00145);

    // R10: output enable acts without a clock
    b_rd_ld(8'h10); tick();
    b_oe_n = 1; #1;
    chk("R10 oe off en", {16'h0, b_dout_en}, 18'h0);
    chk("R10 oe off data", b_dout, 18'h0);
    b_oe_n = 0; #1;
    chk("R10 oe on data", b_dout, 18'h3FE00);

    // R11: same address, same edge writes
    a_wr(8'h40, 18'h11111, 2'b11);
    b_cs_n = 0; b_cs = 1; b_ld_n = 0; b_addr = 8'h40; b_wr_n = 0; b_din = 18'h22222;
    tick();
    b_rd_ld(8'h40); tick();
    chk("R11 A wins", b_dout, 18'h11111);
    a_wr(8'h41, 18'h00000, 2'b01);
    b_cs_n = 0; b_cs = 1; b_ld_n = 0; b_addr = 8'h41; b_wr_n = 0; b_din = 18'h3FFFF;
    tick();
    b_rd_ld(8'h41); tick();
    chk("R11 per lane", b_dout, 18'h3FE00);

    // R12: read during other port's write returns old data
    a_wr(8'h50, 18'h0F0F0, 2'b11); tick();
    a_wr(8'h50, 18'h3C3C3, 2'b11); b_rd_ld(8'h50); tick();
    chk("R12 old data", b_dout, 18'h0F0F0);
    b_rd_ld(8'h50); tick();
    chk("R12 new data", b_dout, 18'h3C3C3);

    // R9: pipelined mode adds one cycle
    b_pipe = 1; tick();
    b_rd_ld(8'h10); tick();
    chk("R9 pipe not yet", {16'h0, b_dout_en}, 18'h0);
    tick();
    chk("R9 pipe data", b_dout, 18'h3FE00);
    chk("R9 pipe en", {16'h0, b_dout_en}, 18'h3);
    b_pipe = 0;

    // R1: reset again, memory kept, counter at 0
    @(negedge clk); rst_n = 0; #1;
    chk("R1 reset en", {16'h0, b_dout_en}, 18'h0);
    @(negedge clk); rst_n = 1;
    repeat (3) tick();
    b_cs_n = 0; b_cs = 1; tick();
    chk("R1 counter zero mem kept", b_dout, 18'h15555);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule